// File: doc/BRIEF.md
# Dual Circular Transfer Buffer

This block holds the data that passes between a processor-side word port and a serial shift engine. It has two circular queues. The outbound queue collects words that software writes, and the shift engine takes them from there. The inbound queue collects words that the shift engine has assembled, and software reads them from there. Software sees both queues through one word location: a write always enters the outbound queue, and a read always takes from the inbound queue.

The queue depth comes from a small mode input. It selects either a single-element holding register or a multi-element ring of four, eight or sixteen slots. Each queue keeps two pointers of its own, one for the side that stores and one for the side that removes. Both pointers wrap at the selected depth. When the module is disabled, or when the depth selection changes, both queues are emptied.

Each queue reports its occupancy and its full and empty state. A sticky overflow flag records an inbound word that arrived while the inbound queue was full. The shift engine may take a word while the outbound queue is empty and substitution is enabled. In that case it receives a programmable fill word, and a sticky underrun flag is raised.

Top module: `dual_ring_xfer`

## Requirements
- R1: After reset both occupancy counts are 0, both empty outputs are 1, both full outputs are 0, and both sticky flags are 0.
- R2: Words written with `cpu_wr` are presented on `ser_tx_word` in write order. Each `ser_tx_take` removes the word at the head.
- R3: Words stored with `ser_rx_put` are presented on `cpu_rdata` in arrival order. Each `cpu_rd` removes the word at the head.
- R4: `depth_sel` gives the queue capacity: 0 gives 1 slot, 1 gives 4, 2 gives 8 and 3 gives 16. A queue's full output is 1 exactly when its count equals that capacity.
- R5: A write to a full outbound queue is discarded. The count and the stored words do not change.
- R6: A word stored into a full inbound queue is discarded, and `rx_overflow` becomes 1 and stays 1 while the module is enabled.
- R7: A take or read on an empty queue has no effect. Its count stays 0, and `cpu_rdata` reads 0 while the inbound queue is empty.
- R8: While the outbound queue is empty, `ser_tx_word` equals `urd_word` when `urd_en` is 1, and 0 otherwise. A take under substitution sets `tx_underrun`, and it stays set. A take with substitution off leaves `tx_underrun` unchanged.
- R9: In a cycle where `enable` is 0 or `depth_sel` differs from its value in the previous cycle, both queues are emptied. Deasserting `enable` also clears both sticky flags.
- R10: The pointers wrap circularly at the selected capacity. Order is preserved over repeated fill and drain rounds that cross the wrap point.
- R11: A store and a removal in the same cycle are both judged on the occupancy at the start of that cycle. On a full queue the removal happens and the store is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Module enable; 0 empties both queues and clears the flags |
| depth_sel | input | 2 | Capacity select: 0=1, 1=4, 2=8, 3=16 |
| cpu_wr | input | 1 | Software write strobe into the outbound queue |
| cpu_wdata | input | DATA_W | Software write word |
| cpu_rd | input | 1 | Software read strobe; removes the head of the inbound queue |
| cpu_rdata | output | DATA_W | Head of the inbound queue, or 0 when it is empty |
| ser_tx_take | input | 1 | Shift engine takes the outbound word |
| ser_tx_word | output | DATA_W | Outbound head, or the fill word, or 0 |
| ser_rx_put | input | 1 | Shift engine stores an inbound word |
| ser_rx_word | input | DATA_W | Inbound word |
| urd_en | input | 1 | Enables fill-word substitution |
| urd_word | input | DATA_W | Fill word sent on underrun |
| tx_count | output | MAX_LOG2+1 | Outbound occupancy |
| rx_count | output | MAX_LOG2+1 | Inbound occupancy |
| tx_full | output | 1 | Outbound queue full |
| tx_empty | output | 1 | Outbound queue empty |
| rx_full | output | 1 | Inbound queue full |
| rx_empty | output | 1 | Inbound queue empty |
| rx_overflow | output | 1 | Sticky inbound overflow flag |
| tx_underrun | output | 1 | Sticky outbound underrun flag |

## Verification
Counts, full and empty outputs and both sticky flags come from registers. They change at the clock edge that captures a strobe and can be observed one edge after the stimulus. The head words on `cpu_rdata` and `ser_tx_word` are read combinationally from the storage. They show the new head once the edge that moved a pointer has passed, and the fill word appears with no delay once the queue is empty. The bench drives its strobes shortly after a rising edge. It checks every registered result right after the next rising edge, and it checks the head words before the strobe that removes them, so each comparison falls inside one settled clock period.

// File: rtl/dual_ring_pkg.sv
package dual_ring_pkg;

   typedef enum logic [1:0] {
      DM_SINGLE  = 2'd0,
      DM_QUAD    = 2'd1,
      DM_OCTAL   = 2'd2,
      DM_SIXTEEN = 2'd3
   } depth_mode_e;

   // log2 of the capacity named by each mode
   function automatic int unsigned mode_log2(input depth_mode_e m);
      case (m)
         DM_SINGLE:  return 0;
         DM_QUAD:    return 2;
         DM_OCTAL:   return 3;
         default:    return 4;
      endcase
   endfunction

endpackage

// File: rtl/dual_ring_queue.sv
module dual_ring_queue #(
   parameter int DATA_W   = 16,
   parameter int MAX_LOG2 = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush,
   input  logic [MAX_LOG2:0]   depth,
   input  logic                push,
   input  logic [DATA_W-1:0]   push_data,
   input  logic                pop,
   output logic [DATA_W-1:0]   head,
   output logic [MAX_LOG2:0]   count,
   output logic                full,
   output logic                empty,
   output logic                push_drop
);
   localparam int SLOTS = 1 << MAX_LOG2;
   localparam int AW    = MAX_LOG2;
   localparam int CW    = MAX_LOG2 + 1;

   logic [DATA_W-1:0] slot_q [SLOTS];
   logic [AW-1:0]     wr_ptr_q;   // storing-side pointer
   logic [AW-1:0]     rd_ptr_q;   // removing-side pointer
   logic [CW-1:0]     cnt_q;
   logic              push_ok, pop_ok;

   function automatic logic [AW-1:0] advance(input logic [AW-1:0] p,
                                             input logic [CW-1:0] d);
      logic [CW-1:0] n;
      n = {1'b0, p} + CW'(1);
      return (n >= d) ? '0 : n[AW-1:0];
   endfunction

   assign full      = (cnt_q == depth);
   assign empty     = (cnt_q == '0);
   assign push_ok   = push & ~full  & ~flush;
   assign pop_ok    = pop  & ~empty & ~flush;
   assign push_drop = push & full & ~flush;
   assign count     = cnt_q;
   assign head      = empty ? '0 : slot_q[rd_ptr_q];

   always_ff @(posedge clk) begin
      if (push_ok) slot_q[wr_ptr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= advance(wr_ptr_q, depth);
         if (pop_ok)  rd_ptr_q <= advance(rd_ptr_q, depth);
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R4: occupancy never exceeds the selected capacity
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (cnt_q <= depth) || flush);

   // R5: a store into a full queue without a removal changes nothing
   p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && full && push && !pop) |=> $stable(cnt_q) && $stable(wr_ptr_q));

   // R7: a removal from an empty queue leaves it empty
   p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && empty && pop && !push) |=> (cnt_q == '0) && $stable(rd_ptr_q));

   // R9: a flush empties the queue
   p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/dual_ring_tx_feed.sv
module dual_ring_tx_feed #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              flush,
   input  logic              urd_en,
   input  logic [DATA_W-1:0] urd_word,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_head,
   input  logic              take,
   output logic [DATA_W-1:0] tx_word,
   output logic              underrun
);
   logic sub_take;

   assign sub_take = take & q_empty & urd_en & ~flush;

   always_comb begin
      if (!q_empty)    tx_word = q_head;
      else if (urd_en) tx_word = urd_word;
      else             tx_word = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) underrun <= 1'b0;
      else if (sub_take)     underrun <= 1'b1;
   end

   // R8: a take under substitution raises the sticky underrun flag
   p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !flush && take && q_empty && urd_en) |=> underrun);

   // R8: the flag stays set while enabled
   p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && enable) |=> (underrun || !$past(enable)) );

endmodule

// File: rtl/dual_ring_xfer.sv
module dual_ring_xfer #(
   parameter int DATA_W   = 16,
   parameter int MAX_LOG2 = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic [1:0]          depth_sel,
   input  logic                cpu_wr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic                cpu_rd,
   output logic [DATA_W-1:0]   cpu_rdata,
   input  logic                ser_tx_take,
   output logic [DATA_W-1:0]   ser_tx_word,
   input  logic                ser_rx_put,
   input  logic [DATA_W-1:0]   ser_rx_word,
   input  logic                urd_en,
   input  logic [DATA_W-1:0]   urd_word,
   output logic [MAX_LOG2:0]   tx_count,
   output logic [MAX_LOG2:0]   rx_count,
   output logic                tx_full,
   output logic                tx_empty,
   output logic                rx_full,
   output logic                rx_empty,
   output logic                rx_overflow,
   output logic                tx_underrun
);
   import dual_ring_pkg::*;

   localparam int CW = MAX_LOG2 + 1;

   generate
      if (MAX_LOG2 < 2 || MAX_LOG2 > 8) begin : g_bad_depth
         $error("dual_ring_xfer: MAX_LOG2 must lie in 2..8");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
         $error("dual_ring_xfer: DATA_W must lie in 1..64");
      end
   endgenerate

   logic [1:0]        sel_q;
   logic              flush;
   logic [CW-1:0]     depth_lim;
   logic [DATA_W-1:0] tx_head;
   logic              rx_drop;
   logic              tx_drop_unused;
   int unsigned       lg;

   always_comb begin
      lg = mode_log2(depth_mode_e'(depth_sel));
      if (lg > MAX_LOG2) lg = MAX_LOG2;
      depth_lim = CW'(1) << lg;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= depth_sel;
   end

   assign flush = ~enable | (depth_sel != sel_q);

   dual_ring_queue #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .depth     (depth_lim),
      .push      (cpu_wr),
      .push_data (cpu_wdata),
      .pop       (ser_tx_take),
      .head      (tx_head),
      .count     (tx_count),
      .full      (tx_full),
      .empty     (tx_empty),
      .push_drop (tx_drop_unused)
   );

   dual_ring_queue #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .depth     (depth_lim),
      .push      (ser_rx_put),
      .push_data (ser_rx_word),
      .pop       (cpu_rd),
      .head      (cpu_rdata),
      .count     (rx_count),
      .full      (rx_full),
      .empty     (rx_empty),
      .push_drop (rx_drop)
   );

   dual_ring_tx_feed #(.DATA_W(DATA_W)) u_feed (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .flush    (flush),
      .urd_en   (urd_en),
      .urd_word (urd_word),
      .q_empty  (tx_empty),
      .q_head   (tx_head),
      .take     (ser_tx_take),
      .tx_word  (ser_tx_word),
      .underrun (tx_underrun)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) rx_overflow <= 1'b0;
      else if (rx_drop)      rx_overflow <= 1'b1;
   end

   // R6: an inbound word arriving at a full queue raises the overflow flag
   p_overflow_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !flush && rx_full && ser_rx_put) |=> rx_overflow);

   // R8: an empty outbound queue with substitution on presents the fill word
   p_fill_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && urd_en) |-> (ser_tx_word == urd_word));

   // R9: disabling clears both sticky flags
   p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !rx_overflow && !tx_underrun);

   // R11: removal from a full queue with a concurrent store drops one word
   p_full_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && tx_full && cpu_wr && ser_tx_take) |=> (tx_count == $past(tx_count) - CW'(1)));

endmodule

// File: tb/dual_ring_xfer_test.sv
module dual_ring_xfer_test;
   localparam int DW = 8;
   localparam int ML = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          enable;
   logic [1:0]    depth_sel;
   logic          cpu_wr, cpu_rd, ser_tx_take, ser_rx_put, urd_en;
   logic [DW-1:0] cpu_wdata, ser_rx_word, urd_word, cpu_rdata, ser_tx_word;
   logic [ML:0]   tx_count, rx_count;
   logic          tx_full, tx_empty, rx_full, rx_empty, rx_overflow, tx_underrun;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model[$];

   always #10 clk = ~clk;

   dual_ring_xfer #(.DATA_W(DW), .MAX_LOG2(ML)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .depth_sel(depth_sel),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
      .ser_tx_take(ser_tx_take), .ser_tx_word(ser_tx_word),
      .ser_rx_put(ser_rx_put), .ser_rx_word(ser_rx_word),
      .urd_en(urd_en), .urd_word(urd_word),
      .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_full(rx_full), .rx_empty(rx_empty), .rx_overflow(rx_overflow),
      .tx_underrun(tx_underrun)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] wgen(input int a, input int b);
      return DW'(a * 53 + b * 7 + 3);
   endfunction

   function automatic int cap(input int s);
      return (s == 0) ? 1 : (1 << (s + 1));
   endfunction

   task automatic wr_tx(input logic [DW-1:0] w);
      cpu_wdata = w; cpu_wr = 1'b1; tick(); cpu_wr = 1'b0;
   endtask

   task automatic put_rx(input logic [DW-1:0] w);
      ser_rx_word = w; ser_rx_put = 1'b1; tick(); ser_rx_put = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; depth_sel = 2'd0;
      cpu_wr = 0; cpu_rd = 0; ser_tx_take = 0; ser_rx_put = 0; urd_en = 0;
      cpu_wdata = '0; ser_rx_word = '0; urd_word = '0;
      tick(); tick();
      rst_n = 1'b1; tick();
      // R1: reset state
      chk("R1 tx_count", tx_count, 0);
      chk("R1 rx_count", rx_count, 0);
      chk("R1 empties", {tx_empty, rx_empty}, 2'b11);
      chk("R1 fulls", {tx_full, rx_full}, 2'b00);
      chk("R1 flags", {rx_overflow, tx_underrun}, 2'b00);

      enable = 1'b1;
      for (int s = 0; s < 4; s++) begin
         int d;
         d = cap(s);
         depth_sel = 2'(s); tick();
         chk("R9 depth change empties", {27'd0, tx_count}, 0);
         // outbound fill past capacity
         model.delete();
         for (int i = 0; i <= d; i++) begin
            wr_tx(wgen(s, i));
            if (i < d) model.push_back(wgen(s, i));
            chk("R4 tx_count", tx_count, (i + 1 < d) ? i + 1 : d);
         end
         chk("R4 tx_full", tx_full, 1);
         chk("R5 full write ignored", tx_count, d);
         for (int i = 0; i < d; i++) begin
            chk("R2 tx order", ser_tx_word, model.pop_front());
            ser_tx_take = 1'b1; tick(); ser_tx_take = 1'b0;
         end
         chk("R2 tx_empty", tx_empty, 1);
         chk("R8 empty word without fill", ser_tx_word, 0);
         ser_tx_take = 1'b1; tick(); ser_tx_take = 1'b0;
         chk("R7 take on empty", tx_count, 0);
         chk("R8 no flag without fill", tx_underrun, 0);
         // inbound fill past capacity
         model.delete();
         for (int i = 0; i <= d; i++) begin
            if (i == d) chk("R6 no overflow before", rx_overflow, 0);
            put_rx(wgen(s + 7, i));
            if (i < d) model.push_back(wgen(s + 7, i));
         end
         chk("R6 overflow set", rx_overflow, 1);
         chk("R6 rx_count", rx_count, d);
         chk("R4 rx_full", rx_full, 1);
         for (int i = 0; i < d; i++) begin
            chk("R3 rx order", cpu_rdata, model.pop_front());
            cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
         end
         chk("R7 rdata zero when empty", cpu_rdata, 0);
         cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
         chk("R7 read on empty", rx_count, 0);
         chk("R6 overflow sticky", rx_overflow, 1);
         // wrap rounds
         for (int r = 0; r < 3; r++) begin
            int n;
            n = (d > 1) ? d - 1 : 1;
            for (int i = 0; i < n; i++) begin
               wr_tx(wgen(r + 20, i)); model.push_back(wgen(r + 20, i));
               put_rx(wgen(r + 40, i));
            end
            for (int i = 0; i < n; i++) begin
               chk("R10 tx wrap order", ser_tx_word, model.pop_front());
               chk("R10 rx wrap order", cpu_rdata, wgen(r + 40, i));
               ser_tx_take = 1'b1; cpu_rd = 1'b1; tick();
               ser_tx_take = 1'b0; cpu_rd = 1'b0;
            end
         end
         chk("R10 both empty", {tx_empty, rx_empty}, 2'b11);
         enable = 1'b0; tick(); enable = 1'b1; tick();
         chk("R9 disable clears flag", rx_overflow, 0);
      end

      // R8: fill word substitution
      depth_sel = 2'd1; tick();
      urd_en = 1'b1; urd_word = 8'hA5; #1;
      chk("R8 fill word shown", ser_tx_word, 8'hA5);
      ser_tx_take = 1'b1; tick(); ser_tx_take = 1'b0;
      chk("R8 underrun set", tx_underrun, 1);
      wr_tx(8'h3C);
      chk("R8 queued word beats fill", ser_tx_word, 8'h3C);
      tick();
      chk("R8 underrun sticky", tx_underrun, 1);
      ser_tx_take = 1'b1; tick(); ser_tx_take = 1'b0;
      urd_en = 1'b0;
      enable = 1'b0; tick(); enable = 1'b1; tick();
      chk("R9 disable clears underrun", tx_underrun, 0);

      // R9: depth change mid-fill empties both queues
      wr_tx(8'h11); put_rx(8'h22);
      chk("R9 pre-change counts", {tx_count, rx_count}, {5'd1, 5'd1});
      depth_sel = 2'd2; tick();
      chk("R9 post-change counts", {tx_count, rx_count}, 10'd0);
      chk("R9 rdata cleared", cpu_rdata, 0);

      // R11: store and removal together on a full queue
      model.delete();
      for (int i = 0; i < 8; i++) begin
         wr_tx(wgen(90, i)); model.push_back(wgen(90, i));
      end
      cpu_wdata = 8'hEE; cpu_wr = 1'b1; ser_tx_take = 1'b1; tick();
      cpu_wr = 1'b0; ser_tx_take = 1'b0;
      void'(model.pop_front());
      chk("R11 full both count", tx_count, 7);
      // R11: both on a partly filled queue keeps the count and accepts the store
      cpu_wdata = 8'h5A; cpu_wr = 1'b1; ser_tx_take = 1'b1; tick();
      cpu_wr = 1'b0; ser_tx_take = 1'b0;
      void'(model.pop_front()); model.push_back(8'h5A);
      chk("R11 partial both count", tx_count, 7);
      for (int i = 0; i < 7; i++) begin
         chk("R11 order after concurrent ops", ser_tx_word, model.pop_front());
         ser_tx_take = 1'b1; tick(); ser_tx_take = 1'b0;
      end
      chk("R11 drained", tx_empty, 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule